// File: doc/BRIEF.md
# Vector Display List Processor

This block steers the beam of a vector-deflection display with no help from the host. The host first points an address register at a word in either the writable RAM region or the fixed ROM region. It then pulses a start line. The engine copies that address into its own program counter and fetches 16-bit control words one after another. For each word it updates a 7-bit X coordinate, a 7-bit Y coordinate and a set of intensity bits. When it fetches an end-of-message word, it stops and raises a completion flag. The flag stays high until the host starts the engine again.

Beam steps are paced by a free-running time base. The time base divides the system clock down to one step interval. It also splits every refresh frame into two equal halves, a trace window and a character window, each lasting a fixed number of step intervals. The host reaches the pointer register and both memory regions over a single shared bidirectional 16-bit bus. Four control lines go with the bus: a start strobe, a register select, a read/write line and a bus enable.

Top module: `vecdisp_engine`

## Requirements
- R1: While reset is high and after it is released, `busy`, `eom_done`, `x_pos`, `y_pos`, `beam_on`, `int_base`, `int_mark` and `char_window` are all 0, and the pointer register reads back 0.
- R2: A `host_start` pulse while idle loads the program counter from the pointer register. `busy` is high from the next cycle, `eom_done` is cleared, and words are fetched from consecutive addresses that wrap within the selected region.
- R3: A word with bits [15:14] = 11 (end-of-message) makes `busy` fall and `eom_done` rise on the same edge. `eom_done` then holds until the next accepted start.
- R4: A word with opcode 00 (draw) or 01 (move) sets `x_pos` to bits [13:7] and `y_pos` to bits [6:0]. `beam_on` becomes 1 for draw and 0 for move.
- R5: Position updates happen only on a step tick, once every `TICK_DIV` clocks. Two back-to-back positioning words are therefore exactly `TICK_DIV` clocks apart (for `TICK_DIV` of at least 3).
- R6: A word with opcode 10 (set intensity) acts without waiting for a tick. Its bit 0 becomes `int_base` and its bit 1 becomes the marker enable. Position and `beam_on` are unchanged.
- R7: A `sync_mark` pulse is held pending until the next draw or move step. That step drives `int_mark` high only if the marker is enabled. The pending event is then consumed, so the step after it drives `int_mark` low.
- R8: With the pointer register selected (`host_rs` = 0), a write loads the region from bit 15 (1 = ROM) and the address from the low `ADDR_W` bits, and a read returns them in the same positions. With the data port selected (`host_rs` = 1), a read returns the addressed word and a write stores to RAM. ROM word k reads as `{2'b00, k, ~k}` with k in 7 bits, except that the last ROM word is 16'hC000. Writes to ROM have no effect.
- R9: While `busy` is high, data-port reads return 16'h0000 and data-port writes leave memory unchanged.
- R10: A `host_start` pulse while `busy` is high is ignored: the running list continues from its own program counter.
- R11: `char_window` starts at 0 and toggles once every `TICK_DIV * POINTS_PER_WIN` clocks. A full frame is two windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_start | input | 1 | Start strobe; ignored while busy |
| host_rs | input | 1 | Register select: 0 pointer register, 1 memory data port |
| host_rw | input | 1 | 1 = read, 0 = write |
| host_en | input | 1 | Bus enable; qualifies an access |
| host_data | inout | 16 | Shared bidirectional data bus |
| sync_mark | input | 1 | Sync event that requests a trace marker |
| x_pos | output | 7 | Beam X coordinate |
| y_pos | output | 7 | Beam Y coordinate |
| beam_on | output | 1 | Beam visible (draw) or blanked (move) |
| int_base | output | 1 | Baseline brightness bit |
| int_mark | output | 1 | Bright marker bit |
| eom_done | output | 1 | End of message reached |
| busy | output | 1 | Engine executing a list |
| char_window | output | 1 | 0 = trace window, 1 = character window |

## Verification
The bench builds the engine with `ADDR_W` = 6, `TICK_DIV` = 4 and `POINTS_PER_WIN` = 5. A step is then four clocks and a window is twenty clocks, so the window toggle and the exact step spacing can be measured directly. It also means a 63-step ROM program finishes in a few hundred cycles. The small address width lets the bench read the last ROM word, which holds the end-of-message code, and lets it run the whole ROM list from its first word to its terminator. With four clocks per step, the bench has enough room to issue pointer, data and start requests while a short RAM list is still running.

// File: rtl/vecdisp_pkg.sv
package vecdisp_pkg;
  localparam int WORD_W  = 16;
  localparam int COORD_W = 7;

  typedef enum logic [1:0] {
    OP_DRAW  = 2'b00,
    OP_MOVE  = 2'b01,
    OP_INTEN = 2'b10,
    OP_EOM   = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DECODE,
    ST_WAIT
  } seq_st_e;

  // Fixed contents of the ROM region: a diagonal test pattern ended by end-of-message.
  function automatic logic [WORD_W-1:0] rom_word(int unsigned idx, int unsigned depth);
    logic [COORD_W-1:0] c;
    c = COORD_W'(idx);
    if (idx == depth - 1) rom_word = {OP_EOM, 14'd0};
    else                  rom_word = {OP_DRAW, c, ~c};
  endfunction
endpackage

// File: rtl/vecdisp_timebase.sv
module vecdisp_timebase #(
  parameter int TICK_DIV       = 1000,
  parameter int POINTS_PER_WIN = 1000
) (
  input  logic clk,
  input  logic rst,
  output logic step_tick,
  output logic char_window
);
  localparam int DIV_W = $clog2(TICK_DIV + 1);
  localparam int PTS_W = $clog2(POINTS_PER_WIN + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);
  localparam logic [PTS_W-1:0] PTS_LAST = PTS_W'(POINTS_PER_WIN - 1);

  logic [DIV_W-1:0] div_cnt;
  logic [PTS_W-1:0] pt_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt   <= '0;
      step_tick <= 1'b0;
    end else begin
      step_tick <= (div_cnt == DIV_LAST);
      if (div_cnt == DIV_LAST) div_cnt <= '0;
      else                     div_cnt <= div_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pt_cnt      <= '0;
      char_window <= 1'b0;
    end else if (step_tick) begin
      if (pt_cnt == PTS_LAST) begin
        pt_cnt      <= '0;
        char_window <= ~char_window;
      end else begin
        pt_cnt <= pt_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/vecdisp_mem.sv
module vecdisp_mem #(
  parameter int ADDR_W = 6
) (
  input  logic                             clk,
  input  logic                             rd_rom,
  input  logic [ADDR_W-1:0]                rd_addr,
  output logic [vecdisp_pkg::WORD_W-1:0]   rdata,
  input  logic                             we,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic [vecdisp_pkg::WORD_W-1:0]   wdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [vecdisp_pkg::WORD_W-1:0] ram [DEPTH];
  logic [vecdisp_pkg::WORD_W-1:0] ram_q;
  logic [vecdisp_pkg::WORD_W-1:0] rom_q;
  logic                           rom_sel_q;

  always_ff @(posedge clk) begin
    if (we) ram[wr_addr] <= wdata;
    ram_q <= ram[rd_addr];
  end

  always_ff @(posedge clk) begin
    rom_q     <= vecdisp_pkg::rom_word(int'(rd_addr), DEPTH);
    rom_sel_q <= rd_rom;
  end

  assign rdata = rom_sel_q ? rom_q : ram_q;
endmodule

// File: rtl/vecdisp_hostif.sv
module vecdisp_hostif #(
  parameter int ADDR_W = 6
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           host_rs,
  input  logic                           host_rw,
  input  logic                           host_en,
  input  logic [vecdisp_pkg::WORD_W-1:0] bus_in,
  output logic [vecdisp_pkg::WORD_W-1:0] bus_out,
  output logic                           bus_oe,
  input  logic                           busy,
  input  logic [vecdisp_pkg::WORD_W-1:0] mem_rdata,
  output logic                           ptr_rom,
  output logic [ADDR_W-1:0]              ptr_addr,
  output logic                           mem_we,
  output logic [vecdisp_pkg::WORD_W-1:0] mem_wdata
);
  localparam int W = vecdisp_pkg::WORD_W;
  logic [W-1:0] ptr_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_rom  <= 1'b0;
      ptr_addr <= '0;
    end else if (host_en && !host_rw && !host_rs) begin
      ptr_rom  <= bus_in[W-1];
      ptr_addr <= bus_in[ADDR_W-1:0];
    end
  end

  always_comb begin
    ptr_word                = '0;
    ptr_word[W-1]           = ptr_rom;
    ptr_word[ADDR_W-1:0]    = ptr_addr;
  end

  assign bus_oe    = host_en && host_rw;
  assign bus_out   = host_rs ? (busy ? '0 : mem_rdata) : ptr_word;
  assign mem_we    = host_en && host_rs && !host_rw && !busy && !ptr_rom;
  assign mem_wdata = bus_in;
endmodule

// File: rtl/vecdisp_seq.sv
module vecdisp_seq #(
  parameter int ADDR_W = 6
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             start,
  input  logic                             ptr_rom,
  input  logic [ADDR_W-1:0]                ptr_addr,
  input  logic                             step_tick,
  input  logic                             sync_mark,
  input  logic [vecdisp_pkg::WORD_W-1:0]   mem_rdata,
  output logic                             mem_rd_rom,
  output logic [ADDR_W-1:0]                mem_rd_addr,
  output logic [vecdisp_pkg::COORD_W-1:0]  x_pos,
  output logic [vecdisp_pkg::COORD_W-1:0]  y_pos,
  output logic                             beam_on,
  output logic                             int_base,
  output logic                             int_mark,
  output logic                             eom_done,
  output logic                             busy
);
  import vecdisp_pkg::*;

  seq_st_e            state;
  logic [ADDR_W-1:0]  pc;
  logic               run_rom;
  logic [WORD_W-1:0]  word_q;
  logic               mark_en;
  logic               sync_q;
  logic               step_now;
  op_e                rd_op;
  op_e                held_op;

  assign rd_op       = op_e'(mem_rdata[WORD_W-1 -: 2]);
  assign held_op     = op_e'(word_q[WORD_W-1 -: 2]);
  assign step_now    = (state == ST_WAIT) && step_tick;
  assign busy        = (state != ST_IDLE);
  assign mem_rd_rom  = busy ? run_rom : ptr_rom;
  assign mem_rd_addr = busy ? pc : ptr_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      pc       <= '0;
      run_rom  <= 1'b0;
      word_q   <= '0;
      eom_done <= 1'b0;
      mark_en  <= 1'b0;
      int_base <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          pc       <= ptr_addr;
          run_rom  <= ptr_rom;
          eom_done <= 1'b0;
          state    <= ST_FETCH;
        end
        ST_FETCH: state <= ST_DECODE;
        ST_DECODE: begin
          case (rd_op)
            OP_EOM: begin
              eom_done <= 1'b1;
              state    <= ST_IDLE;
            end
            OP_INTEN: begin
              int_base <= mem_rdata[0];
              mark_en  <= mem_rdata[1];
              pc       <= pc + 1'b1;
              state    <= ST_FETCH;
            end
            default: begin
              word_q <= mem_rdata;
              state  <= ST_WAIT;
            end
          endcase
        end
        ST_WAIT: if (step_tick) begin
          pc    <= pc + 1'b1;
          state <= ST_FETCH;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Beam outputs change only on an executed positioning step.
  always_ff @(posedge clk) begin
    if (rst) begin
      x_pos    <= '0;
      y_pos    <= '0;
      beam_on  <= 1'b0;
      int_mark <= 1'b0;
      sync_q   <= 1'b0;
    end else begin
      if (step_now) begin
        x_pos    <= word_q[2*COORD_W-1 -: COORD_W];
        y_pos    <= word_q[COORD_W-1:0];
        beam_on  <= (held_op == OP_DRAW);
        int_mark <= mark_en && sync_q;
        sync_q   <= sync_mark;
      end else if (sync_mark) begin
        sync_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/vecdisp_engine.sv
module vecdisp_engine #(
  parameter int ADDR_W         = 6,
  parameter int TICK_DIV       = 1000,
  parameter int POINTS_PER_WIN = 1000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        host_start,
  input  logic        host_rs,
  input  logic        host_rw,
  input  logic        host_en,
  inout  wire  [15:0] host_data,
  input  logic        sync_mark,
  output logic [6:0]  x_pos,
  output logic [6:0]  y_pos,
  output logic        beam_on,
  output logic        int_base,
  output logic        int_mark,
  output logic        eom_done,
  output logic        busy,
  output logic        char_window
);
  localparam int W = vecdisp_pkg::WORD_W;

  logic              step_tick;
  logic [W-1:0]      bus_out;
  logic              bus_oe;
  logic [W-1:0]      mem_rdata;
  logic [W-1:0]      mem_wdata;
  logic              mem_we;
  logic              ptr_rom;
  logic [ADDR_W-1:0] ptr_addr;
  logic              rd_rom;
  logic [ADDR_W-1:0] rd_addr;

  assign host_data = bus_oe ? bus_out : 'z;

  vecdisp_timebase #(.TICK_DIV(TICK_DIV), .POINTS_PER_WIN(POINTS_PER_WIN)) i_timebase (
    .clk(clk), .rst(rst), .step_tick(step_tick), .char_window(char_window)
  );

  vecdisp_hostif #(.ADDR_W(ADDR_W)) i_hostif (
    .clk(clk), .rst(rst), .host_rs(host_rs), .host_rw(host_rw), .host_en(host_en),
    .bus_in(host_data), .bus_out(bus_out), .bus_oe(bus_oe), .busy(busy),
    .mem_rdata(mem_rdata), .ptr_rom(ptr_rom), .ptr_addr(ptr_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata)
  );

  vecdisp_mem #(.ADDR_W(ADDR_W)) i_mem (
    .clk(clk), .rd_rom(rd_rom), .rd_addr(rd_addr), .rdata(mem_rdata),
    .we(mem_we), .wr_addr(ptr_addr), .wdata(mem_wdata)
  );

  vecdisp_seq #(.ADDR_W(ADDR_W)) i_seq (
    .clk(clk), .rst(rst), .start(host_start), .ptr_rom(ptr_rom), .ptr_addr(ptr_addr),
    .step_tick(step_tick), .sync_mark(sync_mark), .mem_rdata(mem_rdata),
    .mem_rd_rom(rd_rom), .mem_rd_addr(rd_addr), .x_pos(x_pos), .y_pos(y_pos),
    .beam_on(beam_on), .int_base(int_base), .int_mark(int_mark),
    .eom_done(eom_done), .busy(busy)
  );
endmodule

// File: rtl/vecdisp_checker.sv
module vecdisp_checker (
  input logic       clk,
  input logic       rst,
  input logic       host_start,
  input logic       busy,
  input logic       eom_done,
  input logic [6:0] x_pos,
  input logic [6:0] y_pos,
  input logic       step_tick,
  input logic       char_window
);
  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (!busy && !eom_done)); // R1

  AST_START_TAKES: assert property (@(posedge clk) disable iff (rst)
    (!busy && host_start) |=> busy); // R2

  AST_EOM_HALTS: assert property (@(posedge clk) disable iff (rst)
    $rose(eom_done) |-> !busy); // R3

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (eom_done && !host_start) |=> eom_done); // R3

  AST_POS_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    ((x_pos != $past(x_pos)) || (y_pos != $past(y_pos))) |-> $past(step_tick)); // R5

  AST_WIN_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    (char_window != $past(char_window)) |-> $past(step_tick)); // R11
endmodule

bind vecdisp_engine vecdisp_checker i_chk (
  .clk(clk), .rst(rst), .host_start(host_start), .busy(busy), .eom_done(eom_done),
  .x_pos(x_pos), .y_pos(y_pos), .step_tick(step_tick), .char_window(char_window)
);

// File: tb/test_vecdisp_engine.sv
module test_vecdisp_engine;
  localparam int ADDR_W = 6;
  localparam int TDIV   = 4;
  localparam int PTS    = 5;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam logic [15:0] EOM = 16'hC000;

  // {word, exp_x, exp_y, exp_beam, exp_base}
  localparam logic [31:0] VEC [8] = '{
    {2'b00, 7'd5,   7'd9,   7'd5,   7'd9,   1'b1, 1'b0},
    {2'b01, 7'd127, 7'd0,   7'd127, 7'd0,   1'b0, 1'b0},
    {2'b10, 14'd1,          7'd127, 7'd0,   1'b0, 1'b1},
    {2'b00, 7'd0,   7'd127, 7'd0,   7'd127, 1'b1, 1'b1},
    {2'b10, 14'd0,          7'd0,   7'd127, 1'b1, 1'b0},
    {2'b01, 7'd64,  7'd64,  7'd64,  7'd64,  1'b0, 1'b0},
    {2'b00, 7'd42,  7'd85,  7'd42,  7'd85,  1'b1, 1'b0},
    {2'b01, 7'd1,   7'd126, 7'd1,   7'd126, 1'b0, 1'b0}
  };

  logic clk = 0;
  logic rst = 1;
  logic h_start = 0, h_rs = 0, h_rw = 0, h_en = 0, sync_mark = 0;
  logic tb_oe = 0;
  logic [15:0] tb_drv = '0;
  wire  [15:0] host_data;
  logic [6:0] x_pos, y_pos;
  logic beam_on, int_base, int_mark, eom_done, busy, char_window;
  int n_chk = 0, n_fail = 0;

  assign host_data = tb_oe ? tb_drv : 'z;
  always #4 clk = ~clk;

  vecdisp_engine #(.ADDR_W(ADDR_W), .TICK_DIV(TDIV), .POINTS_PER_WIN(PTS)) i_vecdisp_engine (
    .clk(clk), .rst(rst), .host_start(h_start), .host_rs(h_rs), .host_rw(h_rw),
    .host_en(h_en), .host_data(host_data), .sync_mark(sync_mark), .x_pos(x_pos),
    .y_pos(y_pos), .beam_on(beam_on), .int_base(int_base), .int_mark(int_mark),
    .eom_done(eom_done), .busy(busy), .char_window(char_window)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic host_op(input bit rs, input bit rw, input logic [15:0] d, output logic [15:0] q);
    @(negedge clk);
    h_rs = rs; h_rw = rw; h_en = 1; tb_oe = !rw; tb_drv = d;
    #1 q = host_data;
    @(negedge clk);
    h_en = 0; tb_oe = 0;
  endtask

  task automatic set_ptr(input logic [15:0] p);
    logic [15:0] q;
    host_op(1'b0, 1'b0, p, q);
  endtask

  task automatic wr_word(input logic [15:0] p, input logic [15:0] d);
    logic [15:0] q;
    set_ptr(p);
    host_op(1'b1, 1'b0, d, q);
  endtask

  task automatic rd_word(input logic [15:0] p, output logic [15:0] q);
    set_ptr(p);
    repeat (2) @(negedge clk);
    host_op(1'b1, 1'b1, 16'h0, q);
  endtask

  task automatic pulse_start();
    @(negedge clk); h_start = 1;
    @(negedge clk); h_start = 0;
  endtask

  task automatic wait_halt();
    int n = 0;
    while (busy && n < 5000) begin @(negedge clk); n++; end
  endtask

  function automatic logic [15:0] rom_exp(int k);
    logic [6:0] c = 7'(k);
    return (k == DEPTH - 1) ? EOM : {2'b00, c, ~c};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected halt");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] q;
    int last_t, gap_bad, t, seen, saw_p, saw_q, prev_cw, len;
    logic [6:0] px;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk({busy, eom_done, x_pos, y_pos, beam_on, int_base, int_mark, char_window} == 0,
        "R1 outputs in reset", {x_pos, y_pos}, 0);
    @(negedge clk); rst = 0;
    host_op(1'b0, 1'b1, 16'h0, q);
    chk(q == 16'h0, "R1 pointer after reset", q, 0);

    // R8: pointer register and memory port
    set_ptr(16'h8005);
    host_op(1'b0, 1'b1, 16'h0, q);
    chk(q == 16'h8005, "R8 pointer readback", q, 16'h8005);
    rd_word(16'h8005, q);
    chk(q == rom_exp(5), "R8 ROM word 5", q, rom_exp(5));
    rd_word(16'h8000 | 16'(DEPTH - 1), q);
    chk(q == EOM, "R8 last ROM word", q, EOM);
    wr_word(16'h8005, 16'hFFFF);
    rd_word(16'h8005, q);
    chk(q == rom_exp(5), "R8 ROM write ignored", q, rom_exp(5));
    wr_word(16'd20, 16'h1234);
    rd_word(16'd20, q);
    chk(q == 16'h1234, "R8 RAM write/read", q, 16'h1234);

    // R4 R6: vector table, each word run alone before an end-of-message
    wr_word(16'd1, EOM);
    for (int i = 0; i < 8; i++) begin
      logic [31:0] v = VEC[i];
      wr_word(16'd0, v[31:16]);
      set_ptr(16'd0);
      pulse_start();
      wait_halt();
      chk({x_pos, y_pos, beam_on, int_base, eom_done} == {v[15:0], 1'b1},
          (v[31:30] == 2'b10) ? "R6 set intensity vector" : "R4 draw/move vector",
          {x_pos, y_pos, beam_on, int_base}, v[15:0]);
    end

    // R2 R3 R5: run the whole ROM list
    set_ptr(16'h8000);
    pulse_start();
    chk(busy && !eom_done, "R2 busy after start", {busy, eom_done}, 2'b10);
    last_t = -1; gap_bad = 0; t = 0; seen = 0; px = x_pos;
    while (busy && t < 5000) begin
      @(negedge clk); t++;
      if (x_pos != px) begin
        if (last_t >= 0 && t - last_t != TDIV) gap_bad++;
        last_t = t; seen++; px = x_pos;
      end
    end
    chk(gap_bad == 0 && seen > 10, "R5 step spacing", gap_bad, 0);
    chk(x_pos == 7'd62 && y_pos == 7'd65 && beam_on, "R2 ROM list final step",
        {x_pos, y_pos}, {7'd62, 7'd65});
    chk(eom_done && !busy, "R3 halted with done", {busy, eom_done}, 2'b01);
    repeat (10) @(negedge clk);
    chk(eom_done && !busy, "R3 done held", {busy, eom_done}, 2'b01);

    // R9 R10: host activity while running
    wr_word(16'd0, {2'b00, 7'd10, 7'd20});
    wr_word(16'd1, {2'b00, 7'd11, 7'd21});
    wr_word(16'd2, EOM);
    wr_word(16'd10, {2'b00, 7'd99, 7'd99});
    wr_word(16'd11, EOM);
    set_ptr(16'd0);
    pulse_start();
    set_ptr(16'd10);
    host_op(1'b1, 1'b0, 16'h0000, q);
    host_op(1'b1, 1'b1, 16'h0, q);
    chk(q == 16'h0, "R9 read while busy", q, 0);
    chk(busy, "R10 still busy at second start", busy, 1);
    pulse_start();
    wait_halt();
    chk(x_pos == 7'd11 && y_pos == 7'd21, "R10 start ignored", {x_pos, y_pos}, {7'd11, 7'd21});
    rd_word(16'd10, q);
    chk(q == {2'b00, 7'd99, 7'd99}, "R9 write ignored", q, {2'b00, 7'd99, 7'd99});

    // R7: marker on the step after a sync event
    wr_word(16'd0, 16'h8003);
    wr_word(16'd1, {2'b00, 7'd30, 7'd30});
    wr_word(16'd2, {2'b00, 7'd31, 7'd31});
    wr_word(16'd3, EOM);
    set_ptr(16'd0);
    @(negedge clk); sync_mark = 1;
    @(negedge clk); sync_mark = 0;
    pulse_start();
    saw_p = 0; saw_q = 0; t = 0;
    while (busy && t < 5000) begin
      @(negedge clk); t++;
      if (int_mark && x_pos == 7'd30) saw_p = 1;
      if (int_mark && x_pos == 7'd31) saw_q = 1;
    end
    chk(saw_p == 1, "R7 marker on first step", saw_p, 1);
    chk(saw_q == 0 && !int_mark, "R7 marker consumed", saw_q, 0);

    // R11: window length
    prev_cw = char_window; t = 0;
    while (char_window == prev_cw && t < 200) begin @(negedge clk); t++; end
    prev_cw = char_window; len = 0;
    while (char_window == prev_cw && len < 200) begin @(negedge clk); len++; end
    chk(len == TDIV * PTS, "R11 window length", len, TDIV * PTS);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule